// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in-first-out store of 64 words held in registers, indexed by a 6-bit stack pointer. A write request stores the value on the push data input; a read request returns the most recently stored word that has not yet been read, on a registered pop data output. Two status flags tell the surrounding logic whether another word can be stored (not full) and whether a word can be read (not empty).

The pointer advances before a write and retreats after a read. On reset it is 0, and the first stored word goes to location 1. The 64th stored word goes to location 0, where the pointer wraps back to 0 and the full flag rises. A pointer of 0 therefore means either no words or all 64 words, and the two flags tell these apart. No separate occupancy count is kept.

Flow control is done through the flags rather than through a handshake. The full flag acts as the not-ready signal for the write side, and the empty flag acts as the not-valid signal for the read side. A request made against the flag is dropped, and so is a request for a write and a read in the same cycle. A dropped request leaves the stack untouched and produces a one-cycle error pulse.

Top module: `regstk`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the stack pointer reads 0, empty is 1, full is 0, error is 0 and the pop data output is 0.
- R2: A write request with the read request low and full at 0 is accepted on that clock edge. The pointer becomes pointer+1, the push data is stored at the new pointer value, and empty goes to 0.
- R3: When an accepted write moves the pointer from 63 to 0, full becomes 1 on the same edge. Before that write, with 63 words stored, full is 0.
- R4: A read request with the write request low and empty at 0 is accepted. The word at the current pointer appears on the pop data output after that clock edge, the pointer becomes pointer-1, and full goes to 0.
- R5: When an accepted read moves the pointer to 0, empty becomes 1.
- R6: A write request while full is 1 is dropped. The pointer and flags are unchanged, error is 1 for the following cycle, and the stored words are untouched: a later read still returns the last accepted word.
- R7: A read request while empty is 1 is dropped. The pointer, flags and pop data output are unchanged, and error is 1 for the following cycle.
- R8: A write request and a read request in the same cycle are both dropped, whatever the flags. Pointer, flags, stored words and pop data are unchanged, and error is 1 for the following cycle.
- R9: The error output is registered. It is 1 only in the cycle after a dropped request and 0 after an idle cycle or an accepted request.
- R10: Words are returned in reverse order of storage across all 64 locations. After 64 writes, the first read returns the 64th word, which is held in location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Write request |
| pop_i | input | 1 | Read request |
| push_data_i | input | DATA_W (16) | Word to store, sampled on the rising edge |
| pop_data_o | output | DATA_W (16) | Data register; last word read |
| sp_o | output | 6 | Stack pointer |
| full_o | output | 1 | All 64 locations hold data |
| empty_o | output | 1 | No location holds data |
| err_o | output | 1 | One-cycle pulse after a dropped request |

## Verification
The hardest condition to reach is the wrap to full. It needs 64 accepted writes in a row, and only then can a dropped write against a full stack and a read of location 0 be seen. The bench fills the stack with a counted pattern and checks the pointer at 63 and again at the wrap. It then attempts a further write and drains the stack while comparing every returned word, which exposes any corruption from the dropped write. Shorter interleaved sequences from a table cover simultaneous requests and reads from an empty stack.

// File: rtl/regstk_pkg.sv
package regstk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_DROP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/regstk_ctrl.sv
module regstk_ctrl
  import regstk_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic             rd_en_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic [PTR_W-1:0] sp_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o
);
  logic [PTR_W-1:0] sp_q, sp_up, sp_dn;
  logic             full_q, empty_q, err_q;
  stk_op_e          op;

  assign sp_up = sp_q + PTR_W'(1);
  assign sp_dn = sp_q - PTR_W'(1);

  always_comb begin
    op = OP_IDLE;
    if (push_i && pop_i)          op = OP_DROP;
    else if (push_i)              op = full_q  ? OP_DROP : OP_PUSH;
    else if (pop_i)               op = empty_q ? OP_DROP : OP_POP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= (op == OP_DROP);
      case (op)
        OP_PUSH: begin
          sp_q    <= sp_up;
          full_q  <= (sp_up == '0);
          empty_q <= 1'b0;
        end
        OP_POP: begin
          sp_q    <= sp_dn;
          full_q  <= 1'b0;
          empty_q <= (sp_dn == '0);
        end
        default: ;
      endcase
    end
  end

  assign wr_en_o   = (op == OP_PUSH);
  assign wr_addr_o = sp_up;
  assign rd_en_o   = (op == OP_POP);
  assign rd_addr_o = sp_q;
  assign sp_o      = sp_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign err_o     = err_q;

  // R2: accepted write advances the pointer by one
  a_r2_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (sp_o == $past(sp_o) + PTR_W'(1)) && !empty_o);
  // R3: write from pointer 63 wraps to 0 and raises full
  a_r3_full_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o && sp_o == {PTR_W{1'b1}}) |=> full_o && sp_o == '0);
  // R4: accepted read retreats the pointer and clears full
  a_r4_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (sp_o == $past(sp_o) - PTR_W'(1)) && !full_o);
  // R5: empty only ever with the pointer at 0
  a_r5_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (sp_o == '0) && !full_o);
  // R8: simultaneous requests leave state alone and flag an error
  a_r8_both_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> $stable(sp_o) && $stable(full_o) && $stable(empty_o) && err_o);
  // R6: write against full is dropped
  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |=> $stable(sp_o) && full_o && err_o);
endmodule

// File: rtl/regstk_mem.sv
module regstk_mem #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] words [DEPTH];
  logic [DATA_W-1:0] dreg_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) words[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       dreg_q <= '0;
    else if (rd_en_i) dreg_q <= words[rd_addr_i];
  end

  assign rd_data_o = dreg_q;

  // R7: data register moves only on an accepted read
  a_r7_dreg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/regstk.sv
module regstk #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [PTR_W-1:0]  sp_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  logic             wr_en, rd_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  initial begin
    if ((1 << PTR_W) != DEPTH)
      $error("regstk: DEPTH must be a power of two for pointer wrap");
  end

  regstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .sp_o      (sp_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .err_o     (err_o)
  );

  regstk_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (push_data_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (pop_data_o)
  );

  // R9: error never persists across an accepted operation
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> !err_o);
endmodule

// File: tb/regstk_tb.sv
module regstk_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0;
  logic        pop_i = 1'b0;
  logic [15:0] push_data_i = '0;
  logic [15:0] pop_data_o;
  logic [5:0]  sp_o;
  logic        full_o, empty_o, err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  regstk u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .push_data_i(push_data_i), .pop_data_o(pop_data_o), .sp_o(sp_o),
    .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
  );

  // row: req(4) push pop data(16) | sp(6) full empty err dout(16)
  localparam int NV = 11;
  localparam logic [46:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b0, 16'hA1A1, 6'd1, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
    {4'd2, 1'b1, 1'b0, 16'hB2B2, 6'd2, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
    {4'd2, 1'b1, 1'b0, 16'hC3C3, 6'd3, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
    {4'd4, 1'b0, 1'b1, 16'h0000, 6'd2, 1'b0, 1'b0, 1'b0, 16'hC3C3}, // R4
    {4'd8, 1'b1, 1'b1, 16'hD4D4, 6'd2, 1'b0, 1'b0, 1'b1, 16'hC3C3}, // R8
    {4'd4, 1'b0, 1'b1, 16'h0000, 6'd1, 1'b0, 1'b0, 1'b0, 16'hB2B2}, // R4 R9
    {4'd2, 1'b1, 1'b0, 16'hE5E5, 6'd2, 1'b0, 1'b0, 1'b0, 16'hB2B2}, // R2
    {4'd4, 1'b0, 1'b1, 16'h0000, 6'd1, 1'b0, 1'b0, 1'b0, 16'hE5E5}, // R4
    {4'd5, 1'b0, 1'b1, 16'h0000, 6'd0, 1'b0, 1'b1, 1'b0, 16'hA1A1}, // R5
    {4'd7, 1'b0, 1'b1, 16'h0000, 6'd0, 1'b0, 1'b1, 1'b1, 16'hA1A1}, // R7
    {4'd8, 1'b1, 1'b1, 16'hF6F6, 6'd0, 1'b0, 1'b1, 1'b1, 16'hA1A1}  // R8
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_out();
    return {sp_o, full_o, empty_o, err_o, pop_data_o};
  endfunction

  task automatic step(input logic ps, input logic pp, input logic [15:0] d);
    @(negedge clk);
    push_i = ps; pop_i = pp; push_data_i = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    chk("R1", pack_out(), {6'd0, 1'b0, 1'b1, 1'b0, 16'h0000});

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][42], VEC[i][41], VEC[i][40:25]);
      chk($sformatf("R%0d row %0d", VEC[i][46:43], i), pack_out(),
          {VEC[i][24:19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0]});
    end
    idle();
    chk("R9 err low after idle", err_o, 1'b0);

    // R3 and R10: fill all 64 words
    do_reset();
    for (int i = 1; i <= 64; i++) begin
      step(1'b1, 1'b0, 16'h1000 + 16'(i));
      if (i == 63) chk("R3 sp 63 not full", {sp_o, full_o}, {6'd63, 1'b0});
    end
    chk("R3 wrap to full", {sp_o, full_o, empty_o}, {6'd0, 1'b1, 1'b0});

    // R6: write while full
    step(1'b1, 1'b0, 16'hDEAD);
    chk("R6 dropped write", {sp_o, full_o, empty_o, err_o}, {6'd0, 1'b1, 1'b0, 1'b1});
    idle();
    chk("R9 err single cycle", err_o, 1'b0);

    // R10: first read returns 64th word from location 0
    step(1'b0, 1'b1, 16'h0);
    chk("R10 top word", pop_data_o, 16'h1040);
    chk("R4 pop from full", {sp_o, full_o}, {6'd63, 1'b0});

    begin
      bit order_ok = 1'b1;
      for (int i = 63; i >= 2; i--) begin
        step(1'b0, 1'b1, 16'h0);
        if (pop_data_o !== 16'h1000 + 16'(i) || empty_o !== 1'b0) order_ok = 1'b0;
      end
      chk("R10 reverse order", order_ok, 1'b1);
    end
    step(1'b0, 1'b1, 16'h0);
    chk("R5 drain to empty", pack_out(), {6'd0, 1'b0, 1'b1, 1'b0, 16'h1001});

    // R7: read while empty keeps data register
    step(1'b0, 1'b1, 16'h0);
    chk("R7 dropped read", pack_out(), {6'd0, 1'b0, 1'b1, 1'b1, 16'h1001});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule